// File: doc/BRIEF.md
# Predicated Vector Lane ALU

This block applies one integer operation to every element of a vector whose width scales in 128-bit steps. Two source vectors and the previous destination vector come in together with a byte-granular predicate, an element-size code, an operation code, a mode bit that picks between keeping and clearing disabled elements, and an effective-length code. One registered result vector comes out a cycle later.

The same byte-sliced datapath serves 8, 16, 32 and 64-bit elements. Carries stop at element boundaries. A lane is enabled by the predicate bit of its lowest byte. Lanes past the effective length are always cleared. The predicate presented here is the one already chosen from the eight governing predicates; selecting it is left to the surrounding pipeline.

Top module: `pvalu_top`

## Requirements
- R1: With op = 00 (and also op = 11), each active element becomes src_a + src_b modulo 2^element width, with no carry into the neighbouring element.
- R2: With op = 01, each active element becomes src_a - src_b modulo 2^element width.
- R3: With op = 10, each active element becomes the unsigned absolute difference |src_a - src_b| of that element.
- R4: esize selects the element width: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits.
- R5: An element starting at byte k is active exactly when pred[k] is 1; predicate bits for the element's higher bytes have no effect.
- R6: With zmode = 0, an inactive element inside the effective length takes the value of dst_old.
- R7: With zmode = 1, an inactive element inside the effective length is written as zero.
- R8: The effective length is (vl_gran + 1) x 128 bits; every result byte at or above that length is zero, whatever the predicate and mode.
- R9: out_valid is high exactly one cycle after in_valid; when in_valid is low the result register holds its value.
- R10: After reset out_valid is 0 and result is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid, loads the result register |
| op | input | 2 | 00 add, 01 subtract, 10 absolute difference, 11 add |
| esize | input | 2 | Element width code |
| zmode | input | 1 | 0 keep inactive elements, 1 clear them |
| vl_gran | input | 4 | Effective length in 128-bit granules minus one |
| pred | input | 256 | Predicate, one bit per byte |
| src_a | input | 2048 | First source vector |
| src_b | input | 2048 | Second source vector |
| dst_old | input | 2048 | Destination value before the operation |
| out_valid | output | 1 | Result valid |
| result | output | 2048 | Result vector |

## Verification
All-ones plus one and zero minus one per element size show whether carries and borrows are confined to their element and whether wrapping is correct. A predicate with only the non-lowest bits of each element set separates the lowest-byte enable rule from any other bit choice, and the same random operands run once in each mode tell keeping apart from clearing. The smallest and a middle effective length expose tail handling, and long random runs over every size, operation, mode and length compare whole vectors with a model that works per element rather than per byte.

// File: rtl/pvalu_pkg.sv
package pvalu_pkg;

  typedef enum logic [1:0] {
    OP_ADD     = 2'b00,
    OP_SUB     = 2'b01,
    OP_ABD     = 2'b10,
    OP_ADD_ALT = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SEL_RES  = 2'b00,
    SEL_OLD  = 2'b01,
    SEL_ZERO = 2'b10
  } bsel_e;

  // low-byte-offset mask of an element: bytes per element minus one
  function automatic logic [2:0] elem_mask(logic [1:0] esz);
    case (esz)
      2'b00:   elem_mask = 3'd0;
      2'b01:   elem_mask = 3'd1;
      2'b10:   elem_mask = 3'd3;
      default: elem_mask = 3'd7;
    endcase
  endfunction

endpackage

// File: rtl/pvalu_seg_add.sv
module pvalu_seg_add #(
  parameter int VW = 2048,
  localparam int VB = VW / 8
) (
  input  logic [VW-1:0] a,
  input  logic [VW-1:0] b,
  input  logic          cin,
  input  logic [1:0]    esz,
  output logic [VW-1:0] sum,
  output logic [VB-1:0] cout
);
  import pvalu_pkg::*;

  logic [2:0] m;
  assign m = elem_mask(esz);

  // byte-sliced adder, carry chain restarts at each element's first byte
  always_comb begin : p_chain
    logic       c;
    logic [8:0] t;
    c = 1'b0;
    for (int i = 0; i < VB; i++) begin
      if ((3'(i) & m) == 3'd0) c = cin;
      t = {1'b0, a[8*i +: 8]} + {1'b0, b[8*i +: 8]} + {8'd0, c};
      sum[8*i +: 8] = t[7:0];
      c = t[8];
      cout[i] = c;
    end
  end

endmodule

// File: rtl/pvalu_lane_ctl.sv
module pvalu_lane_ctl #(
  parameter int VW = 2048,
  localparam int VB = VW / 8,
  localparam int GW = $clog2(VW / 128)
) (
  input  logic [VB-1:0]   pred,
  input  logic [1:0]      esz,
  input  logic            zmode,
  input  logic [GW-1:0]   vl_gran,
  output logic [2*VB-1:0] bsel
);
  import pvalu_pkg::*;

  logic [2:0] m;
  int         live_bytes;
  assign m          = elem_mask(esz);
  assign live_bytes = (int'(vl_gran) + 1) * 16;

  always_comb begin
    for (int i = 0; i < VB; i++) begin
      int base;
      base = i & ~int'(m);
      if (i >= live_bytes)     bsel[2*i +: 2] = SEL_ZERO;
      else if (pred[base])     bsel[2*i +: 2] = SEL_RES;
      else if (zmode)          bsel[2*i +: 2] = SEL_ZERO;
      else                     bsel[2*i +: 2] = SEL_OLD;
    end
  end

endmodule

// File: rtl/pvalu_top.sv
module pvalu_top #(
  parameter int VW = 2048,
  localparam int VB = VW / 8,
  localparam int GW = $clog2(VW / 128)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    op,
  input  logic [1:0]    esize,
  input  logic          zmode,
  input  logic [GW-1:0] vl_gran,
  input  logic [VB-1:0] pred,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  input  logic [VW-1:0] dst_old,
  output logic          out_valid,
  output logic [VW-1:0] result
);
  import pvalu_pkg::*;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  op_e        op_c;
  logic       negb;
  logic [2:0] m;
  assign op_c = op_e'(op);
  assign negb = (op_c == OP_SUB) || (op_c == OP_ABD);
  assign m    = elem_mask(esize);

  logic [VW-1:0] fwd_b, fwd_sum, rev_sum;
  logic [VB-1:0] fwd_cout, rev_cout;
  assign fwd_b = negb ? ~src_b : src_b;

  pvalu_seg_add #(.VW(VW)) u_fwd (
    .a(src_a), .b(fwd_b), .cin(negb), .esz(esize),
    .sum(fwd_sum), .cout(fwd_cout)
  );

  pvalu_seg_add #(.VW(VW)) u_rev (
    .a(src_b), .b(~src_a), .cin(1'b1), .esz(esize),
    .sum(rev_sum), .cout(rev_cout)
  );

  logic [2*VB-1:0] bsel;
  pvalu_lane_ctl #(.VW(VW)) u_ctl (
    .pred(pred), .esz(esize), .zmode(zmode), .vl_gran(vl_gran), .bsel(bsel)
  );

  // next-state
  logic [VW-1:0] res_d;
  always_comb begin
    for (int i = 0; i < VB; i++) begin
      int         top;
      logic [7:0] alu;
      top = i | int'(m);
      // b - a has no borrow while a - b borrows only when a < b
      if (op_c == OP_ABD && rev_cout[top] && !fwd_cout[top]) alu = rev_sum[8*i +: 8];
      else                                                    alu = fwd_sum[8*i +: 8];
      case (bsel_e'(bsel[2*i +: 2]))
        SEL_RES: res_d[8*i +: 8] = alu;
        SEL_OLD: res_d[8*i +: 8] = dst_old[8*i +: 8];
        default: res_d[8*i +: 8] = 8'd0;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result    <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= res_d;
    end
  end

endmodule

// File: rtl/pvalu_chk.sv
module pvalu_chk #(
  parameter int VW = 2048,
  localparam int VB = VW / 8,
  localparam int GW = $clog2(VW / 128)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          zmode,
  input logic [GW-1:0] vl_gran,
  input logic [VB-1:0] pred,
  input logic [VW-1:0] dst_old,
  input logic          out_valid,
  input logic [VW-1:0] result
);

  logic [GW-1:0] vl_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        vl_q <= '0;
    else if (in_valid) vl_q <= vl_gran;
  end

  function automatic logic [VW-1:0] live_mask(logic [GW-1:0] g);
    for (int i = 0; i < VW; i++) live_mask[i] = (i < (int'(g) + 1) * 128);
  endfunction

  p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  p_tail_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((result & ~live_mask(vl_q)) == '0));

  p_merge_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !zmode && !pred[0]) |=> (result[7:0] == $past(dst_old[7:0])));

  p_zero_inactive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && zmode && !pred[0]) |=> (result[7:0] == 8'd0));

endmodule

bind pvalu_top pvalu_chk #(.VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .in_valid(in_valid), .zmode(zmode),
  .vl_gran(vl_gran), .pred(pred), .dst_old(dst_old),
  .out_valid(out_valid), .result(result)
);

// File: tb/sim_pvalu_top.sv
`timescale 1ns/1ps
module sim_pvalu_top;
  localparam int VW = 2048;
  localparam int VB = VW / 8;
  localparam int GW = $clog2(VW / 128);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    op = '0, esize = '0;
  logic          zmode = 1'b0;
  logic [GW-1:0] vl_gran = '0;
  logic [VB-1:0] pred = '0;
  logic [VW-1:0] src_a = '0, src_b = '0, dst_old = '0;
  logic          out_valid;
  logic [VW-1:0] result;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pvalu_top #(.VW(VW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .esize(esize),
    .zmode(zmode), .vl_gran(vl_gran), .pred(pred), .src_a(src_a),
    .src_b(src_b), .dst_old(dst_old), .out_valid(out_valid), .result(result)
  );

  function automatic logic [VW-1:0] rnd_vec();
    logic [VW-1:0] v;
    for (int w = 0; w < VW / 32; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  function automatic logic [VB-1:0] rnd_pred();
    logic [VB-1:0] v;
    for (int w = 0; w < VB / 32; w++) v[32*w +: 32] = $urandom;
    return v;
  endfunction

  // per-element behavioural model
  function automatic logic [VW-1:0] model(logic [VW-1:0] a, logic [VW-1:0] b,
      logic [VW-1:0] old, logic [VB-1:0] p, int es, int opc, bit z, int vl);
    logic [VW-1:0] r;
    logic [63:0] ea, eb, eo, er, m;
    int nb;
    nb = 1 << es;
    m = (nb == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * nb)) - 64'd1);
    r = '0;
    for (int i = 0; i < VB; i += nb) begin
      ea = '0; eb = '0; eo = '0;
      for (int k = 0; k < nb; k++) begin
        ea[8*k +: 8] = a[8*(i+k) +: 8];
        eb[8*k +: 8] = b[8*(i+k) +: 8];
        eo[8*k +: 8] = old[8*(i+k) +: 8];
      end
      case (opc)
        1:       er = ea - eb;
        2:       er = (ea >= eb) ? ea - eb : eb - ea;
        default: er = ea + eb;
      endcase
      er = er & m;
      if (i >= (vl + 1) * 16) er = '0;
      else if (!p[i])         er = z ? 64'd0 : eo;
      for (int k = 0; k < nb; k++) r[8*(i+k) +: 8] = er[8*k +: 8];
    end
    return r;
  endfunction

  task automatic check_bit(string tag, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic check_vec(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_one(string tag, logic [VW-1:0] a, logic [VW-1:0] b,
      logic [VW-1:0] old, logic [VB-1:0] p, int es, int opc, bit z, int vl);
    logic [VW-1:0] exp;
    exp = model(a, b, old, p, es, opc, z, vl);
    @(negedge clk);
    src_a = a; src_b = b; dst_old = old; pred = p;
    esize = 2'(es); op = 2'(opc); zmode = z; vl_gran = GW'(vl);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit({tag, " valid"}, out_valid, 1'b1);
    check_vec(tag, result, exp);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [VW-1:0] ones, a, b, o, held;
    logic [VB-1:0] pall, phigh;
    void'($urandom(32'd20240611));
    ones  = '1;
    pall  = '1;
    phigh = {(VB/4){4'b1110}};

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check_bit("R10 out_valid", out_valid, 1'b0);
    check_vec("R10 result", result, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bit("R10 after release", out_valid, 1'b0);

    // R1 wrap per element, all sizes (R4)
    for (int es = 0; es < 4; es++) begin
      b = '0;
      for (int i = 0; i < VB; i += (1 << es)) b[8*i +: 8] = 8'd1;
      run_one("R1 R4 add wrap", ones, b, rnd_vec(), pall, es, 0, 1'b0, 15);
    end
    run_one("R1 op11 add", rnd_vec(), rnd_vec(), rnd_vec(), pall, 2, 3, 1'b0, 15);
    // R2 borrow wrap
    for (int es = 0; es < 4; es++) begin
      b = '0;
      for (int i = 0; i < VB; i += (1 << es)) b[8*i +: 8] = 8'd1;
      run_one("R2 R4 sub wrap", '0, b, rnd_vec(), pall, es, 1, 1'b0, 15);
    end
    // R3 absolute difference both orderings
    for (int es = 0; es < 4; es++) begin
      a = rnd_vec(); b = rnd_vec();
      run_one("R3 abd", a, b, rnd_vec(), pall, es, 2, 1'b0, 15);
      run_one("R3 abd swapped", b, a, rnd_vec(), pall, es, 2, 1'b0, 15);
      run_one("R3 abd equal", a, a, rnd_vec(), pall, es, 2, 1'b0, 15);
    end
    // R5 upper predicate bits ignored
    o = rnd_vec();
    run_one("R5 high bits only", rnd_vec(), rnd_vec(), o, phigh, 2, 0, 1'b0, 15);
    check_vec("R5 keeps old", result, o);
    run_one("R5 low bits only", rnd_vec(), rnd_vec(), o, ~phigh, 3, 1, 1'b1, 15);
    // R6 / R7 same operands in both modes
    a = rnd_vec(); b = rnd_vec(); o = rnd_vec();
    run_one("R6 merge", a, b, o, rnd_pred(), 1, 0, 1'b0, 15);
    run_one("R7 zero", a, b, o, rnd_pred(), 1, 0, 1'b1, 15);
    // R8 effective length
    run_one("R8 min length", rnd_vec(), rnd_vec(), rnd_vec(), pall, 0, 0, 1'b0, 0);
    run_one("R8 mid length", rnd_vec(), rnd_vec(), rnd_vec(), rnd_pred(), 3, 2, 1'b0, 6);
    // R9 hold while idle
    held = result;
    @(negedge clk);
    src_a = rnd_vec(); src_b = rnd_vec(); dst_old = rnd_vec(); pred = rnd_pred();
    @(negedge clk);
    check_bit("R9 idle valid", out_valid, 1'b0);
    check_vec("R9 idle hold", result, held);

    // random mix
    for (int n = 0; n < 300; n++) begin
      run_one("random", rnd_vec(), rnd_vec(), rnd_vec(), rnd_pred(),
              int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
              1'($urandom_range(0, 1)), int'($urandom_range(0, 15)));
    end

    done = 1'b1;
    summary();
  end

endmodule